// File: doc/BRIEF.md
# Interrupt Aggregation and Injection Controller

This block collects the raw interrupt request lines of the peripherals and presents them to the processor as a 32-entry interrupt vector. Every raw line first passes through a two-flop synchronizer. The synchronized lines that belong to one vector entry are then OR-combined into that entry's output.

Software sees a small 32-bit register port with three kinds of register:
- A read-only identify register per vector entry. It shows which of the entry's sub-sources is currently active.
- A software request register. Through it any vector entry can be raised or dropped by hand, for test or for injecting interrupts.
- A 5-bit selector. It picks one of the 32 vector lines and mirrors it onto a separate non-maskable interrupt output.

The processor's own interrupt controller, priority handling and the peripherals themselves lie outside this block.

Raw lines arrive grouped, four per vector entry: line `4*n+k` is sub-source `k` of entry `n`. Only the sub-sources that exist for an entry take part. The absent and reserved ones are ignored everywhere.

Top module: `irq_gather_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `irq_out`, `nmi_out` and `reg_rdata` are zero. This holds even if raw lines are high during reset. The request register and the selector then read back as zero.
- R2: A raw line of a present sub-source shows on its `irq_out` bit exactly two rising clock edges after it is set up, and not after one. Its release takes the same two edges.
- R3: The sub-sources that exist are these:
  - Entry 4 has sub-sources 0 and 1.
  - Entry 5 has sub-sources 0 to 2.
  - Entries 6 and 7 each have sub-sources 0 to 3.
  - Entries 0–3, 8–15, 18, 28 and 29 each have sub-source 0 only.
  - All other entries are reserved.
  
  `irq_out[n]` is the OR of entry n's present synchronized sub-sources and request bit n. Raw lines of absent sub-sources and reserved entries have no effect.
- R4: A read of byte offset `4*n` (n < 32) returns entry n's synchronized present sub-sources, with sub-source k in bit k. All other bits read zero, and so does every bit of a reserved entry.
- R5: Writing offset 0x84 with bit n set, while request bit n is 0, sets it. `irq_out[n]` is high from the write's clock edge on.
- R6: Writing 1 to a request bit that is already 1 clears it. A written 0 leaves the request bit unchanged.
- R7: A read of offset 0x84 returns the 32 request bits.
- R8: A write to offset 0x80 stores bits 4:0 as the selector, and a read of 0x80 returns it in bits 4:0 with zeros above. `nmi_out` equals `irq_out[selector]`.
- R9: Reads of offsets 0x88 to 0xFC return zero. Writes to identify offsets or to unmapped offsets change no register.
- R10: Read data appears on `reg_rdata` on the edge that samples `reg_rd`. In any cycle after an edge without `reg_rd`, it is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 128 | Raw peripheral lines, line 4*n+k is sub-source k of entry n |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 32 | Interrupt vector toward the processor |
| nmi_out | output | 1 | Non-maskable interrupt, the selected vector line |

## Verification
The bench checks the synchronizer delay edge by edge. A design with one stage too few or too many would raise the vector bit a cycle early or late.

Absent sub-sources and reserved entries are driven high on purpose. A design that ORs the whole four-line group would raise the line, or show nonzero identify bits, where none should appear.

The request register is driven with 1-over-0, 1-over-1 and 0 writes, and with a mixed pattern. This catches a design that writes the value straight in instead of toggling, or that lets a 0 clear a bit.

The selector is tested with upper data bits set and through both the hardware and the software paths. Unmapped writes are followed by readback, to expose decoding that ignores upper address bits.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int IRQ_SUB_MAX = 4;

  // Present sub-sources of each vector entry; zero marks a reserved entry.
  function automatic logic [IRQ_SUB_MAX-1:0] sub_mask(input int vec);
    case (vec)
      4:                         sub_mask = 4'b0011;
      5:                         sub_mask = 4'b0111;
      6, 7:                      sub_mask = 4'b1111;
      0, 1, 2, 3,
      8, 9, 10, 11, 12, 13, 14, 15,
      18, 28, 29:                sub_mask = 4'b0001;
      default:                   sub_mask = 4'b0000;
    endcase
  endfunction

  // Register word indices (byte offset divided by four).
  localparam int IDX_NMI_SEL = 32;
  localparam int IDX_SW_REQ  = 33;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 128,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int NUM_VEC = 32,
  parameter int SUB_W   = irq_pkg::IRQ_SUB_MAX
) (
  input  logic [NUM_VEC*SUB_W-1:0] sync_lines,
  output logic [NUM_VEC*SUB_W-1:0] id_bits,
  output logic [NUM_VEC-1:0]       hw_vec
);

  genvar v;
  generate
    for (v = 0; v < NUM_VEC; v++) begin : g_vec
      localparam logic [SUB_W-1:0] MASK = irq_pkg::sub_mask(v);
      logic [SUB_W-1:0] live;
      assign live                     = sync_lines[v*SUB_W +: SUB_W] & MASK;
      assign id_bits[v*SUB_W +: SUB_W] = live;
      assign hw_vec[v]                = |live;
    end
  endgenerate

endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int NUM_VEC = 32,
  parameter int SUB_W   = irq_pkg::IRQ_SUB_MAX,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int SEL_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  input  logic [NUM_VEC*SUB_W-1:0] id_bits,
  output logic [DATA_W-1:0]        reg_rdata,
  output logic [NUM_VEC-1:0]       sw_req,
  output logic [SEL_W-1:0]         nmi_sel
);

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IDX_NMI = IDX_W'(irq_pkg::IDX_NMI_SEL);
  localparam logic [IDX_W-1:0] IDX_SW  = IDX_W'(irq_pkg::IDX_SW_REQ);

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rd_val;
  logic              hit_sw;
  logic              hit_nmi;

  assign idx     = reg_addr[ADDR_W-1:2];
  assign hit_sw  = (idx == IDX_SW);
  assign hit_nmi = (idx == IDX_NMI);

  // Software request bits toggle where a 1 is written.
  always_ff @(posedge clk) begin
    if (rst)                  sw_req <= '0;
    else if (reg_wr && hit_sw) sw_req <= sw_req ^ reg_wdata[NUM_VEC-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                   nmi_sel <= '0;
    else if (reg_wr && hit_nmi) nmi_sel <= reg_wdata[SEL_W-1:0];
  end

  always_comb begin
    rd_val = '0;
    if (hit_sw) begin
      rd_val[NUM_VEC-1:0] = sw_req;
    end else if (hit_nmi) begin
      rd_val[SEL_W-1:0] = nmi_sel;
    end else begin
      for (int v = 0; v < NUM_VEC; v++) begin
        if (idx == IDX_W'(v)) rd_val[SUB_W-1:0] = id_bits[v*SUB_W +: SUB_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
    else             reg_rdata <= '0;
  end

endmodule

// File: rtl/irq_gather_ctrl.sv
module irq_gather_ctrl #(
  parameter int NUM_VEC     = 32,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SUB_W      = irq_pkg::IRQ_SUB_MAX,
  localparam int LINES      = NUM_VEC * SUB_W,
  localparam int SEL_W      = $clog2(NUM_VEC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  src_req,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_VEC-1:0] irq_out,
  output logic              nmi_out
);

  logic [LINES-1:0]   sync_lines;
  logic [LINES-1:0]   id_bits;
  logic [NUM_VEC-1:0] hw_vec;
  logic [NUM_VEC-1:0] sw_req_q;
  logic [SEL_W-1:0]   nmi_sel_q;

  irq_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (src_req),
    .dout (sync_lines)
  );

  irq_combine #(.NUM_VEC(NUM_VEC), .SUB_W(SUB_W)) u_combine (
    .sync_lines (sync_lines),
    .id_bits    (id_bits),
    .hw_vec     (hw_vec)
  );

  irq_regs #(
    .NUM_VEC(NUM_VEC), .SUB_W(SUB_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .id_bits   (id_bits),
    .reg_rdata (reg_rdata),
    .sw_req    (sw_req_q),
    .nmi_sel   (nmi_sel_q)
  );

  // Both operands come straight from flops: one gate level to the pins.
  assign irq_out = hw_vec | sw_req_q;
  assign nmi_out = irq_out[nmi_sel_q];

endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk #(
  parameter int NUM_VEC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int LINES   = 128
) (
  input logic               clk,
  input logic               rst,
  input logic [LINES-1:0]   src_req,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic [NUM_VEC-1:0] irq_out,
  input logic               nmi_out,
  input logic [NUM_VEC-1:0] sw_req
);

  localparam logic [ADDR_W-1:0] SW_ADDR = ADDR_W'(8'h84);

  logic [1:0] settle;
  always_ff @(posedge clk) begin
    if (rst)              settle <= '0;
    else if (settle != 2'd3) settle <= settle + 2'd1;
  end

  AST_SYNC_RISE: assert property (@(posedge clk) disable iff (rst)
    (settle == 2'd3 && $past(src_req[0], 2)) |-> irq_out[0]); // R2

  AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (rst)
    (settle == 2'd3 && !$past(src_req[0], 2) && !sw_req[0]) |-> !irq_out[0]); // R2

  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (rst)
    irq_out[16] |-> sw_req[16]); // R3

  AST_SW_RAISE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == SW_ADDR && reg_wdata[0] && !sw_req[0]) |=> irq_out[0]); // R5

  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == SW_ADDR && reg_wdata[0] && sw_req[0]) |=> !sw_req[0]); // R6

  AST_SW_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == SW_ADDR) |=>
      (((sw_req ^ $past(sw_req)) & ~$past(reg_wdata[NUM_VEC-1:0])) == '0)); // R6

  AST_NMI_IDLE: assert property (@(posedge clk) disable iff (rst)
    (irq_out == '0) |-> !nmi_out); // R8

  AST_NMI_ALL: assert property (@(posedge clk) disable iff (rst)
    (&irq_out) |-> nmi_out); // R8

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == '0)); // R10

endmodule

bind irq_gather_ctrl irq_gather_chk #(
  .NUM_VEC(NUM_VEC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LINES(LINES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_req   (src_req),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_out   (irq_out),
  .nmi_out   (nmi_out),
  .sw_req    (sw_req_q)
);

// File: tb/irq_gather_ctrl_bench.sv
module irq_gather_ctrl_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] src = '0;
  logic         reg_wr = 1'b0;
  logic         reg_rd = 1'b0;
  logic [7:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [31:0]  irq_out;
  logic         nmi_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  irq_gather_ctrl u_irq_gather_ctrl (
    .clk(clk), .rst(rst), .src_req(src), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .nmi_out(nmi_out)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    tick();
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic sw_clear_all();
    logic [31:0] cur;
    rd(8'h84, cur);
    wr(8'h84, cur);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    src[0] = 1'b1; src[24] = 1'b1;
    tick(); tick(); tick();
    chk("R1 irq_out in reset", irq_out, 32'h0);
    chk("R1 nmi_out in reset", {31'h0, nmi_out}, 32'h0);
    src = '0;
    tick();
    rst = 1'b0;
    tick();
    chk("R1 irq_out after reset", irq_out, 32'h0);
    chk("R1 rdata after reset", reg_rdata, 32'h0);
    rd(8'h84, d); chk("R1 request reg zero", d, 32'h0);
    rd(8'h80, d); chk("R1 selector zero", d, 32'h0);
  endtask

  task automatic t_sync_latency();
    src[8*4] = 1'b1;
    tick();
    chk("R2 not after one edge", {31'h0, irq_out[8]}, 32'h0);
    tick();
    chk("R2 high after two edges", {31'h0, irq_out[8]}, 32'h1);
    src[8*4] = 1'b0;
    tick();
    chk("R2 still high one edge after release", {31'h0, irq_out[8]}, 32'h1);
    tick();
    chk("R2 low two edges after release", {31'h0, irq_out[8]}, 32'h0);
  endtask

  task automatic t_combine();
    logic [31:0] d;
    src[6*4+2] = 1'b1;
    src[4*4+3] = 1'b1;
    src[5*4+0] = 1'b1; src[5*4+2] = 1'b1;
    src[20*4+0] = 1'b1;
    src[0*4+1] = 1'b1;
    tick(); tick();
    chk("R3 entry 6 from sub 2", {31'h0, irq_out[6]}, 32'h1);
    chk("R3 entry 4 absent sub ignored", {31'h0, irq_out[4]}, 32'h0);
    chk("R3 entry 5 raised", {31'h0, irq_out[5]}, 32'h1);
    chk("R3 reserved entry 20 ignored", {31'h0, irq_out[20]}, 32'h0);
    chk("R3 entry 0 absent sub 1 ignored", {31'h0, irq_out[0]}, 32'h0);
    rd(8'h18, d); chk("R4 identify entry 6", d, 32'h4);
    rd(8'h10, d); chk("R4 identify entry 4 absent bit", d, 32'h0);
    rd(8'h14, d); chk("R4 identify entry 5", d, 32'h5);
    rd(8'h50, d); chk("R4 identify reserved entry 20", d, 32'h0);
    rd(8'h00, d); chk("R4 identify entry 0 unused bit", d, 32'h0);
    src = '0;
    src[7*4+0] = 1'b1; src[7*4+3] = 1'b1;
    tick(); tick();
    rd(8'h1C, d); chk("R4 identify entry 7 two subs", d, 32'h9);
    src[7*4+0] = 1'b0;
    tick(); tick();
    chk("R3 entry 7 held by remaining sub", {31'h0, irq_out[7]}, 32'h1);
    src = '0;
    tick(); tick();
    chk("R3 all lines idle", irq_out, 32'h0);
  endtask

  task automatic t_sw_request();
    logic [31:0] d;
    wr(8'h84, 32'h0001_0000);
    chk("R5 reserved entry raised by software", irq_out, 32'h0001_0000);
    rd(8'h84, d); chk("R7 request readback", d, 32'h0001_0000);
    wr(8'h84, 32'h0);
    chk("R6 zero write leaves bit", irq_out, 32'h0001_0000);
    wr(8'h84, 32'h0001_0000);
    chk("R6 one over one clears", irq_out, 32'h0);
    wr(8'h84, 32'h0000_0003);
    wr(8'h84, 32'h0000_0005);
    rd(8'h84, d); chk("R6 mixed toggle pattern", d, 32'h0000_0006);
    chk("R5 outputs follow requests", irq_out, 32'h0000_0006);
    tick();
    chk("R10 rdata zero without strobe", reg_rdata, 32'h0);
    sw_clear_all();
    chk("R6 cleared by writing back", irq_out, 32'h0);
  endtask

  task automatic t_nmi();
    logic [31:0] d;
    wr(8'h80, 32'd16);
    chk("R8 selected idle line", {31'h0, nmi_out}, 32'h0);
    wr(8'h84, 32'h0001_0000);
    chk("R8 nmi from software line", {31'h0, nmi_out}, 32'h1);
    rd(8'h80, d); chk("R8 selector readback", d, 32'd16);
    wr(8'h80, 32'hFFFF_FFF1);
    rd(8'h80, d); chk("R8 selector keeps 5 bits", d, 32'h11);
    chk("R8 other line not routed", {31'h0, nmi_out}, 32'h0);
    sw_clear_all();
    wr(8'h80, 32'd8);
    src[8*4] = 1'b1;
    tick();
    chk("R8 hardware nmi not early", {31'h0, nmi_out}, 32'h0);
    tick();
    chk("R8 hardware nmi after sync", {31'h0, nmi_out}, 32'h1);
    src = '0;
    tick(); tick();
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h80, 32'd3);
    wr(8'h84, 32'h0000_0100);
    rd(8'h88, d); chk("R9 read 0x88 zero", d, 32'h0);
    rd(8'hFC, d); chk("R9 read 0xFC zero", d, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h88, 32'hFFFF_FFFF);
    wr(8'hC4, 32'hFFFF_FFFF);
    wr(8'hC0, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R9 identify write ignored", d, 32'h0);
    rd(8'h84, d); chk("R9 request unchanged", d, 32'h0000_0100);
    rd(8'h80, d); chk("R9 selector unchanged", d, 32'd3);
    chk("R9 outputs unchanged", irq_out, 32'h0000_0100);
    sw_clear_all();
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sync_latency();
    t_combine();
    t_sw_request();
    t_nmi();
    t_unmapped();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule